// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block counts hardware events in four physical counters. Software reaches it through a 64-bit register port. Every physical counter is 32 bits wide. At run time a counter can be set to count as one 32-bit counter or as two separate 16-bit counters. Split this way, the bank offers up to eight logical counters. Each logical counter has a control word with two jobs: it picks one event line out of a parameterised event bus, and it gates that line.

Values written to a counter do not change the running count. They wait in a staging latch. The latch is copied into the counter when the global control word is written with its enable bit set. The copy happens even when the enable bit was already set. A sticky status word records counter wraps and clears when it is read. A trace window reads one 128-bit entry from an external trace store as two 64-bit words and steps the trace index after the upper word is read.

Top module: `pmc_unit`

## Requirements
- R1: After reset, all of the following read as zero: every counter, every control word, the global control word, the status word and the trace index. `rd_valid` is low.
- R2: Register data occupies bus bits 63:32. Bits 31:0 are ignored on write. They read as zero for every address except the two trace words. Read data appears on `rd_data` with `rd_valid` high in the cycle after the request.
- R3: The word address map is as follows:
  - 0–3: physical counters.
  - 4–11: control words for logical counters 0–7.
  - 12: global control.
  - 13: status.
  - 14: trace index.
  - 15: trace word low.
  - 16: trace word high.
- R4: A logical counter advances by one on each clock in which three conditions hold: its selected event line is high, global control bit 31 is set, and bit 31 of its own control word is set. Control bits 3:0 select the event line.
- R5: When global control bit p (p < 4) is clear, physical counter p is one 32-bit counter driven by logical counter p. The control word of logical counter p+4 then has no effect.
- R6: When global control bit p is set, the upper 16 bits of counter p are logical counter p and the lower 16 bits are logical counter p+4. The two halves count independently, and a wrap of the lower half never carries into the upper half.
- R7: A write to a physical counter address loads only a staging latch. The running value is replaced by the latched value on a write to global control with bit 31 set. This holds even if the unit is already enabled.
- R8: A read of a physical counter returns the staged value while a write is uncommitted, and the live count otherwise.
- R9: With global control bit 31 clear, no counter changes, and the held values stay readable.
- R10: A counter wrap sets a bit in the status word. In 32-bit mode the bit is p. In split mode the upper half sets bit p and the lower half sets bit p+4. A status read returns these bits in data bits 7:0 and clears them. A wrap that happens in the same cycle as the read stays set.
- R11: Reading the low trace word returns bits 63:0 of `trace_data`, and reading the high word returns bits 127:64. Each high-word read adds one to the trace index. The index is writable, readable and drives `trace_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address |
| req_wdata | input | 64 | Write data, field in bits 63:32 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| events | input | 16 | Event lines |
| trace_addr | output | 8 | Trace entry index |
| trace_data | input | 128 | Trace entry at `trace_addr` |

## Verification
The assertions assume the following about the inputs:
- At most one register access arrives per cycle, so a counter write and a commit never reach the same slice together.
- `trace_data` is a settled function of `trace_addr` when a trace word is read.

The stimulus changes requests and events only on falling edges. Each request is held for exactly one rising edge. Event lines stay low while the bank is being configured, so every count the bench expects comes from the number of rising edges during which an event pulse was held.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BUS_W  = 64;
    localparam int unsigned TR_W   = 128;

    typedef enum logic [2:0] {
        CLS_CTR,
        CLS_CTL,
        CLS_GCTL,
        CLS_STAT,
        CLS_TIDX,
        CLS_TLO,
        CLS_THI,
        CLS_NONE
    } reg_cls_e;

endpackage

// File: rtl/pmc_evgate.sv
module pmc_evgate #(
    parameter int unsigned NUM_EVENTS = 16,
    localparam int unsigned SEL_W     = $clog2(NUM_EVENTS)
) (
    input  logic                  glob_en,
    input  logic                  loc_en,
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_EVENTS-1:0] events,
    output logic                  inc
);

    always_comb begin
        inc = glob_en && loc_en && events[sel];
    end

endmodule

// File: rtl/pmc_slice.sv
module pmc_slice #(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split,
    input  logic             inc_hi,
    input  logic             inc_lo,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             commit,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] staged,
    output logic             pend,
    output logic             wrap_hi,
    output logic             wrap_lo
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             pend;
    } slice_t;

    slice_t st_d, st_q;
    logic [HALF_W-1:0] hi_q, lo_q;
    logic              load;

    always_comb begin
        st_d    = st_q;
        wrap_hi = 1'b0;
        wrap_lo = 1'b0;
        hi_q    = st_q.cnt[CNT_W-1:HALF_W];
        lo_q    = st_q.cnt[HALF_W-1:0];
        load    = commit && st_q.pend;

        if (split) begin
            if (inc_hi) begin
                st_d.cnt[CNT_W-1:HALF_W] = hi_q + 1'b1;
                wrap_hi = &hi_q;
            end
            if (inc_lo) begin
                st_d.cnt[HALF_W-1:0] = lo_q + 1'b1;
                wrap_lo = &lo_q;
            end
        end else if (inc_hi) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_hi  = &st_q.cnt;
        end

        if (wr_en) begin
            st_d.latch = wr_val;
            st_d.pend  = 1'b1;
        end

        if (load) begin
            st_d.cnt  = st_q.latch;
            st_d.pend = 1'b0;
            wrap_hi   = 1'b0;
            wrap_lo   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign staged = st_q.latch;
    assign pend   = st_q.pend;

    AST_HALF_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !inc_hi && !(commit && st_q.pend)) |=> $stable(st_q.cnt[CNT_W-1:HALF_W])); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_hi && !inc_lo && !(commit && st_q.pend)) |=> $stable(st_q.cnt)); // R9
    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && st_q.pend && !wr_en) |=> (st_q.cnt == $past(st_q.latch)) && !st_q.pend); // R7

endmodule

// File: rtl/pmc_unit.sv
module pmc_unit #(
    parameter int unsigned NUM_PHYS   = 4,
    parameter int unsigned NUM_EVENTS = 16,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned TR_AW      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [pmc_pkg::BUS_W-1:0]     req_wdata,
    output logic                          rd_valid,
    output logic [pmc_pkg::BUS_W-1:0]     rd_data,
    input  logic [NUM_EVENTS-1:0]         events,
    output logic [TR_AW-1:0]              trace_addr,
    input  logic [pmc_pkg::TR_W-1:0]      trace_data
);
    import pmc_pkg::*;

    localparam int unsigned NUM_LOG = 2 * NUM_PHYS;
    localparam int unsigned SEL_W   = $clog2(NUM_EVENTS);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(NUM_PHYS);
    localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(3 * NUM_PHYS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3 * NUM_PHYS + 1);
    localparam logic [ADDR_W-1:0] A_TIDX = ADDR_W'(3 * NUM_PHYS + 2);
    localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'(3 * NUM_PHYS + 3);
    localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'(3 * NUM_PHYS + 4);
    localparam int unsigned EN_BIT = WORD_W - 1;

    typedef struct packed {
        logic [NUM_LOG-1:0][WORD_W-1:0] ctl;
        logic [WORD_W-1:0]              gctl;
        logic [NUM_LOG-1:0]             stat;
        logic [TR_AW-1:0]               tidx;
        logic                           rd_valid;
        logic [BUS_W-1:0]               rd_data;
    } regs_t;

    regs_t r_d, r_q;
    reg_cls_e cls;
    logic wr, rd, commit;
    logic [WORD_W-1:0] wdat, rval;
    logic [NUM_PHYS-1:0] wr_en_v, pend_v, wrap_hi_v, wrap_lo_v;
    logic [NUM_PHYS-1:0][WORD_W-1:0] cnt_v, staged_v;
    logic [NUM_LOG-1:0] inc_v, wraps;
    logic unused_low;

    assign wr         = req_valid && req_write;
    assign rd         = req_valid && !req_write;
    assign wdat       = req_wdata[BUS_W-1:WORD_W];
    assign unused_low = ^req_wdata[WORD_W-1:0];
    assign commit     = wr && (cls == CLS_GCTL) && wdat[EN_BIT];
    assign wraps      = {wrap_lo_v, wrap_hi_v};

    always_comb begin
        if (req_addr < A_CTL)        cls = CLS_CTR;
        else if (req_addr < A_GCTL)  cls = CLS_CTL;
        else if (req_addr == A_GCTL) cls = CLS_GCTL;
        else if (req_addr == A_STAT) cls = CLS_STAT;
        else if (req_addr == A_TIDX) cls = CLS_TIDX;
        else if (req_addr == A_TLO)  cls = CLS_TLO;
        else if (req_addr == A_THI)  cls = CLS_THI;
        else                         cls = CLS_NONE;
    end

    for (genvar l = 0; l < NUM_LOG; l++) begin : g_gate
        pmc_evgate #(.NUM_EVENTS(NUM_EVENTS)) u_gate (
            .glob_en (r_q.gctl[EN_BIT]),
            .loc_en  (r_q.ctl[l][EN_BIT]),
            .sel     (r_q.ctl[l][SEL_W-1:0]),
            .events  (events),
            .inc     (inc_v[l])
        );
    end

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
        assign wr_en_v[p] = wr && (cls == CLS_CTR) && (req_addr == ADDR_W'(p));
        pmc_slice #(.CNT_W(WORD_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .split   (r_q.gctl[p]),
            .inc_hi  (inc_v[p]),
            .inc_lo  (inc_v[p + NUM_PHYS]),
            .wr_en   (wr_en_v[p]),
            .wr_val  (wdat),
            .commit  (commit),
            .cnt     (cnt_v[p]),
            .staged  (staged_v[p]),
            .pend    (pend_v[p]),
            .wrap_hi (wrap_hi_v[p]),
            .wrap_lo (wrap_lo_v[p])
        );
    end

    always_comb begin
        rval = '0;
        case (cls)
            CLS_CTR: begin
                for (int p = 0; p < NUM_PHYS; p++)
                    if (req_addr == ADDR_W'(p)) rval = pend_v[p] ? staged_v[p] : cnt_v[p];
            end
            CLS_CTL: begin
                for (int l = 0; l < NUM_LOG; l++)
                    if (req_addr == A_CTL + ADDR_W'(l)) rval = r_q.ctl[l];
            end
            CLS_GCTL: rval = r_q.gctl;
            CLS_STAT: rval = WORD_W'(r_q.stat);
            CLS_TIDX: rval = WORD_W'(r_q.tidx);
            default:  rval = '0;
        endcase
    end

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = rd;
        r_d.rd_data  = '0;
        if (rd) begin
            case (cls)
                CLS_TLO: r_d.rd_data = trace_data[BUS_W-1:0];
                CLS_THI: r_d.rd_data = trace_data[TR_W-1:BUS_W];
                default: r_d.rd_data = {rval, {WORD_W{1'b0}}};
            endcase
        end

        if (wr) begin
            case (cls)
                CLS_CTL: begin
                    for (int l = 0; l < NUM_LOG; l++)
                        if (req_addr == A_CTL + ADDR_W'(l)) r_d.ctl[l] = wdat;
                end
                CLS_GCTL: r_d.gctl = wdat;
                CLS_TIDX: r_d.tidx = wdat[TR_AW-1:0];
                default: ;
            endcase
        end

        if (rd && cls == CLS_THI) r_d.tidx = r_q.tidx + 1'b1;
        r_d.stat = ((rd && cls == CLS_STAT) ? '0 : r_q.stat) | wraps;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid   = r_q.rd_valid;
    assign rd_data    = r_q.rd_data;
    assign trace_addr = r_q.tidx;

    AST_TRACE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cls == CLS_THI) |=> (r_q.tidx == TR_AW'($past(r_q.tidx) + 1'b1))); // R11
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cls != CLS_TLO && cls != CLS_THI) |=> (rd_valid && rd_data[WORD_W-1:0] == '0)); // R2
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cls == CLS_STAT && wraps == '0) |=> (r_q.stat == '0)); // R10
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.gctl[EN_BIT] && !wr) |=> $stable(cnt_v)); // R9

endmodule

// File: tb/sim_pmc_unit.sv
`timescale 1ns/1ps
module sim_pmc_unit;

    localparam logic [4:0] A_CTR  = 5'd0;
    localparam logic [4:0] A_CTL  = 5'd4;
    localparam logic [4:0] A_GCTL = 5'd12;
    localparam logic [4:0] A_STAT = 5'd13;
    localparam logic [4:0] A_TIDX = 5'd14;
    localparam logic [4:0] A_TLO  = 5'd15;
    localparam logic [4:0] A_THI  = 5'd16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [4:0]   req_addr = '0;
    logic [63:0]  req_wdata = '0;
    logic         rd_valid;
    logic [63:0]  rd_data;
    logic [15:0]  events = '0;
    logic [7:0]   trace_addr;
    logic [127:0] trace_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [127:0] tr_entry(input logic [7:0] a);
        logic [31:0] z;
        z = {24'd0, a};
        return {32'hC0DE_0000 | z, 32'hFACE_0000 | z, 32'hBEEF_0000 | z, 32'hCAFE_0000 | z};
    endfunction

    assign trace_data = tr_entry(trace_addr);

    pmc_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .events(events), .trace_addr(trace_addr),
        .trace_data(trace_data)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = {d, 32'hDEAD_BEEF};
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        v = rd_valid ? rd_data : 64'hxxxx_xxxx_xxxx_xxxx;
    endtask

    task automatic pulse(input logic [15:0] m, input int n);
        @(negedge clk);
        events = m;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        @(negedge clk);
        chk("R1 rd_valid idle", {63'd0, rd_valid}, 64'd0);
        rd(A_CTR + 5'd2, v);     chk("R1 counter2", v, 64'd0);
        rd(A_CTL + 5'd5, v);     chk("R1 control5", v, 64'd0);
        rd(A_GCTL, v);           chk("R1 global control", v, 64'd0);
        rd(A_STAT, v);           chk("R1 status", v, 64'd0);
        rd(A_TIDX, v);           chk("R1 trace index", v, 64'd0);
    endtask

    task automatic t_count32();
        logic [63:0] v;
        wr(A_CTL + 5'd0, 32'h8000_0002);
        wr(A_CTL + 5'd4, 32'h8000_0003);
        wr(A_GCTL, 32'h8000_0000);
        pulse(16'h000C, 5);
        rd(A_CTR + 5'd0, v);     chk("R4 R5 32-bit count ignores partner", v, {32'd5, 32'd0});
        rd(A_CTL + 5'd4, v);     chk("R2 control readback low half zero", v, {32'h8000_0003, 32'd0});
        rd(A_GCTL, v);           chk("R3 global control at 12", v, {32'h8000_0000, 32'd0});
    endtask

    task automatic t_staging();
        logic [63:0] v;
        wr(A_CTL + 5'd1, 32'h8000_0004);
        wr(A_GCTL, 32'h0000_0000);
        wr(A_CTR + 5'd1, 32'h1234_0000);
        rd(A_CTR + 5'd1, v);     chk("R8 pending value visible", v, {32'h1234_0000, 32'd0});
        wr(A_GCTL, 32'h8000_0000);
        pulse(16'h0010, 3);
        rd(A_CTR + 5'd1, v);     chk("R7 commit then count", v, {32'h1234_0003, 32'd0});
        wr(A_CTR + 5'd1, 32'h0000_0010);
        pulse(16'h0010, 2);
        rd(A_CTR + 5'd1, v);     chk("R8 staged while live runs", v, {32'h0000_0010, 32'd0});
        wr(A_GCTL, 32'h8000_0000);
        pulse(16'h0010, 1);
        rd(A_CTR + 5'd1, v);     chk("R7 rewrite of enable commits", v, {32'h0000_0011, 32'd0});
    endtask

    task automatic t_split();
        logic [63:0] v;
        wr(A_CTL + 5'd2, 32'h8000_0005);
        wr(A_CTL + 5'd6, 32'h8000_0006);
        wr(A_CTR + 5'd2, 32'h0001_FFFF);
        wr(A_GCTL, 32'h8000_0004);
        pulse(16'h0040, 1);
        rd(A_CTR + 5'd2, v);     chk("R6 lower wraps without carry", v, {32'h0001_0000, 32'd0});
        rd(A_STAT, v);           chk("R10 lower half sets bit p+4", v, {32'h0000_0040, 32'd0});
        pulse(16'h0020, 2);
        rd(A_CTR + 5'd2, v);     chk("R6 upper half counts alone", v, {32'h0003_0000, 32'd0});
        rd(A_STAT, v);           chk("R10 status cleared by read", v, 64'd0);
    endtask

    task automatic t_wrap32();
        logic [63:0] v;
        wr(A_CTL + 5'd3, 32'h8000_0007);
        wr(A_CTR + 5'd3, 32'hFFFF_FFFE);
        wr(A_GCTL, 32'h8000_0004);
        pulse(16'h0080, 3);
        rd(A_CTR + 5'd3, v);     chk("R4 32-bit wrap value", v, {32'h0000_0001, 32'd0});
        rd(A_STAT, v);           chk("R10 32-bit wrap sets bit p", v, {32'h0000_0008, 32'd0});
    endtask

    task automatic t_stop();
        logic [63:0] v;
        wr(A_GCTL, 32'h0000_0004);
        pulse(16'h00BC, 4);
        rd(A_CTR + 5'd3, v);     chk("R9 disabled counter 3 held", v, {32'h0000_0001, 32'd0});
        rd(A_CTR + 5'd2, v);     chk("R9 disabled counter 2 held", v, {32'h0003_0000, 32'd0});
        rd(A_CTR + 5'd0, v);     chk("R9 disabled counter 0 held", v, {32'd5, 32'd0});
    endtask

    task automatic t_trace();
        logic [63:0] v;
        logic [127:0] e;
        wr(A_TIDX, 32'h0000_0005);
        e = tr_entry(8'd5);
        rd(A_TLO, v);            chk("R11 low trace word", v, e[63:0]);
        rd(A_THI, v);            chk("R11 high trace word", v, e[127:64]);
        rd(A_TIDX, v);           chk("R11 index stepped", v, {32'd6, 32'd0});
        e = tr_entry(8'd6);
        rd(A_TLO, v);            chk("R11 next entry low word", v, e[63:0]);
        rd(A_TIDX, v);           chk("R11 low read leaves index", v, {32'd6, 32'd0});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count32();
        t_staging();
        t_split();
        t_wrap32();
        t_stop();
        t_trace();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule